// File: doc/BRIEF.md
# Floppy Controller Strap Latch and Drive Output Stage

This block sits between the register file of a floppy disk controller and the drive-side pins. While hardware reset is held, it samples two strap pins, the identity strap and the shared encoding pin, and latches one of three host-interface personalities. From the latched personality it derives three things: whether DMA gating is used, the polarity of the terminal-count pin, and whether the two auxiliary status registers can be read. The shared encoding pin is an input only during reset. After reset it drives the controller's encoding choice again.

On the drive side, the block takes the drive-select field and the four motor bits of the digital output register. The motor bits drive the motor-enable pins directly. The select field is decoded one-hot, and each select is gated by the motor bit of the same drive. A polarity strap sets all disk-control outputs to active high or active low. The density-select pin follows the live identity input, which chooses which level means a high data rate.

Top module: `fdc_strap_drive`

## Requirements
- R1: While `rst` is high, each clock edge latches the personality from {`ident_i`,`mfm_pin_i`}. The encodings on `mode_o` are: 11 gives 0 (gated), 01 gives 1 (ungated), 00 gives 2 (gated with status).
- R2: Strap value 10 is illegal. It sets `mode_illegal_o` to 1 and latches personality 0. Legal values clear `mode_illegal_o`.
- R3: After `rst` falls, `mode_o` and `mode_illegal_o` hold their values whatever the straps do.
- R4: `mfm_oe_o` is 0 while `rst` is high and 1 otherwise. `mfm_out_o` always equals `mfm_sel_i`.
- R5: `dma_gate_en_o` is 1 in personalities 0 and 2, and 0 in personality 1.
- R6: `tc_o` is active high in every personality. It equals `tc_pin_i` in personalities 0 and 2, and the inverse of `tc_pin_i` in personality 1.
- R7: In personality 0, `st_rdata_o` reads 8'hFF and `st_rd_o` stays 0. In personalities 1 and 2, `st_rdata_o` equals `st_data_i` and `st_rd_o` equals `st_rd_i`.
- R8: Motor enable k is asserted exactly when bit k of `dor_mot_i` is 1.
- R9: Drive select k is asserted only when `dor_sel_i` equals k and bit k of `dor_mot_i` is 1. At most one select is asserted.
- R10: With `invert_i` high, all disk-control outputs (`me_o`, `ds_o`, `hdsel_o`, `step_o`, `dir_o`, `we_o`, `wdata_o`) are active high. With `invert_i` low, they are all active low.
- R11: `densel_o` equals `hi_rate_i` when `ident_i` is 1 and its inverse when `ident_i` is 0, using the live `ident_i` value after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hardware reset, active high; strap sampling window |
| ident_i | input | 1 | Identity strap / live drive-type input |
| mfm_pin_i | input | 1 | Shared encoding pin read value (pulled up) |
| mfm_sel_i | input | 1 | Controller encoding choice to drive on the shared pin |
| mfm_out_o | output | 1 | Shared pin drive value |
| mfm_oe_o | output | 1 | Shared pin output enable |
| invert_i | input | 1 | Disk-control polarity strap |
| mode_o | output | 2 | Latched personality |
| mode_illegal_o | output | 1 | Illegal strap combination seen in reset |
| dma_gate_en_o | output | 1 | DMA gating enabled |
| tc_pin_i | input | 1 | Terminal count pin |
| tc_o | output | 1 | Terminal count, active high |
| st_rd_i | input | 1 | Auxiliary status read strobe from host |
| st_data_i | input | 8 | Auxiliary status contents |
| st_rd_o | output | 1 | Status read strobe forwarded to register file |
| st_rdata_o | output | 8 | Status read data to host |
| dor_sel_i | input | 2 | Drive-select field of the output register |
| dor_mot_i | input | 4 | Motor bits of the output register |
| hd_i | input | 1 | Head select, internal active high |
| step_i | input | 1 | Step, internal active high |
| dir_i | input | 1 | Direction, internal active high |
| we_i | input | 1 | Write enable, internal active high |
| wdata_i | input | 1 | Serial write data, internal active high |
| hi_rate_i | input | 1 | High data rate selected |
| me_o | output | 4 | Motor enable pins |
| ds_o | output | 4 | Drive select pins |
| hdsel_o | output | 1 | Head select pin |
| step_o | output | 1 | Step pin |
| dir_o | output | 1 | Direction pin |
| we_o | output | 1 | Write enable pin |
| wdata_o | output | 1 | Write data pin |
| densel_o | output | 1 | Density select pin |

## Verification
The hardest case to reach from the ports is showing that the latched personality ignores the straps once reset has ended. Either strap can flip at any time, and the identity input must keep steering the density pin while it no longer touches the personality. The stimulus runs a reset with each of the four strap combinations. After each reset it toggles both straps freely for many cycles, along with random register and control inputs. A behavioural model, updated only on reset edges, is compared against every output on each clock.

// File: rtl/fdc_strap_drive.sv
module fdc_strap_drive #(
  parameter int NDRV = 4,
  parameter int SRW  = 8,
  localparam int SELW = $clog2(NDRV)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ident_i,
  input  logic            mfm_pin_i,
  input  logic            mfm_sel_i,
  output logic            mfm_out_o,
  output logic            mfm_oe_o,
  input  logic            invert_i,
  output logic [1:0]      mode_o,
  output logic            mode_illegal_o,
  output logic            dma_gate_en_o,
  input  logic            tc_pin_i,
  output logic            tc_o,
  input  logic            st_rd_i,
  input  logic [SRW-1:0]  st_data_i,
  output logic            st_rd_o,
  output logic [SRW-1:0]  st_rdata_o,
  input  logic [SELW-1:0] dor_sel_i,
  input  logic [NDRV-1:0] dor_mot_i,
  input  logic            hd_i,
  input  logic            step_i,
  input  logic            dir_i,
  input  logic            we_i,
  input  logic            wdata_i,
  input  logic            hi_rate_i,
  output logic [NDRV-1:0] me_o,
  output logic [NDRV-1:0] ds_o,
  output logic            hdsel_o,
  output logic            step_o,
  output logic            dir_o,
  output logic            we_o,
  output logic            wdata_o,
  output logic            densel_o
);
  localparam logic [1:0] MODE_GATED   = 2'd0;
  localparam logic [1:0] MODE_UNGATED = 2'd1;
  localparam logic [1:0] MODE_GATED_SR = 2'd2;

  logic [1:0] mode_q;
  logic       illegal_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      illegal_q <= ident_i & ~mfm_pin_i;
      unique case ({ident_i, mfm_pin_i})
        2'b01:   mode_q <= MODE_UNGATED;
        2'b00:   mode_q <= MODE_GATED_SR;
        default: mode_q <= MODE_GATED;
      endcase
    end
  end

  assign mode_o         = mode_q;
  assign mode_illegal_o = illegal_q;
  assign mfm_oe_o       = ~rst;
  assign mfm_out_o      = mfm_sel_i;

  logic ungated, sr_avail;
  assign ungated       = (mode_q == MODE_UNGATED);
  assign sr_avail      = (mode_q != MODE_GATED);
  assign dma_gate_en_o = ~ungated;
  assign tc_o          = tc_pin_i ^ ungated;
  assign st_rd_o       = st_rd_i & sr_avail;
  assign st_rdata_o    = sr_avail ? st_data_i : {SRW{1'b1}};

  logic [NDRV-1:0] ds_act;
  logic            pol_n;
  assign pol_n = ~invert_i;

  for (genvar k = 0; k < NDRV; k++) begin : g_drv
    assign ds_act[k] = (dor_sel_i == SELW'(k)) & dor_mot_i[k];
  end

  assign me_o     = dor_mot_i ^ {NDRV{pol_n}};
  assign ds_o     = ds_act ^ {NDRV{pol_n}};
  assign hdsel_o  = hd_i ^ pol_n;
  assign step_o   = step_i ^ pol_n;
  assign dir_o    = dir_i ^ pol_n;
  assign we_o     = we_i ^ pol_n;
  assign wdata_o  = wdata_i ^ pol_n;
  assign densel_o = hi_rate_i ^ ~ident_i;

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(mode_o) && $stable(mode_illegal_o)); // R3
  AST_ILLEGAL_FALLBACK: assert property (@(posedge clk) disable iff (rst)
    mode_illegal_o |-> dma_gate_en_o && st_rdata_o == {SRW{1'b1}}); // R2
  AST_MFM_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> mfm_oe_o); // R4
  AST_STATUS_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    mode_o == MODE_GATED |-> !st_rd_o && st_rdata_o == {SRW{1'b1}}); // R7
  AST_DS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ds_o ^ {NDRV{pol_n}})); // R9
  AST_DS_NEEDS_MOTOR: assert property (@(posedge clk) disable iff (rst)
    ((ds_o ^ {NDRV{pol_n}}) & ~(me_o ^ {NDRV{pol_n}})) == '0); // R9
  AST_TC_GATE_PAIR: assert property (@(posedge clk) disable iff (rst)
    dma_gate_en_o |-> tc_o == tc_pin_i); // R6
endmodule

// File: tb/fdc_strap_drive_tb_top.sv
module fdc_strap_drive_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic ident = 1, mfm_pin = 1, mfm_sel = 0, invert = 0;
  logic tc_pin = 0, st_rd = 0, hd = 0, step = 0, dir = 0, we = 0, wd = 0, hi_rate = 0;
  logic [7:0] st_data = 0;
  logic [1:0] sel = 0;
  logic [3:0] mot = 0;

  logic mfm_out, mfm_oe, illegal, gate, tc, st_rd_o, hdsel, step_o, dir_o, we_o, wd_o, densel;
  logic [1:0] mode;
  logic [7:0] st_rdata;
  logic [3:0] me, ds;

  int checks = 0, fails = 0, cycles = 0;
  int exp_mode = 0;
  bit exp_ill = 0;
  bit armed = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdc_strap_drive dut_i (
    .clk(clk), .rst(rst), .ident_i(ident), .mfm_pin_i(mfm_pin), .mfm_sel_i(mfm_sel),
    .mfm_out_o(mfm_out), .mfm_oe_o(mfm_oe), .invert_i(invert), .mode_o(mode),
    .mode_illegal_o(illegal), .dma_gate_en_o(gate), .tc_pin_i(tc_pin), .tc_o(tc),
    .st_rd_i(st_rd), .st_data_i(st_data), .st_rd_o(st_rd_o), .st_rdata_o(st_rdata),
    .dor_sel_i(sel), .dor_mot_i(mot), .hd_i(hd), .step_i(step), .dir_i(dir),
    .we_i(we), .wdata_i(wd), .hi_rate_i(hi_rate), .me_o(me), .ds_o(ds),
    .hdsel_o(hdsel), .step_o(step_o), .dir_o(dir_o), .we_o(we_o), .wdata_o(wd_o),
    .densel_o(densel)
  );

  // reference: personality captured on each reset edge
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      armed <= 1;
      exp_ill <= (ident == 1 && mfm_pin == 0);
      if (ident == 0 && mfm_pin == 1) exp_mode <= 1;
      else if (ident == 0 && mfm_pin == 0) exp_mode <= 2;
      else exp_mode <= 0;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int pol(bit v);
    return invert ? int'(v) : int'(!v);
  endfunction

  always @(negedge clk) begin
    if (armed) begin
      int exp_me, exp_ds;
      chk("R1 mode", mode, exp_mode);
      chk("R2 illegal", illegal, exp_ill);
      chk("R4 oe", mfm_oe, rst ? 0 : 1);
      chk("R4 out", mfm_out, mfm_sel);
      chk("R5 gate", gate, exp_mode == 1 ? 0 : 1);
      chk("R6 tc", tc, exp_mode == 1 ? !tc_pin : tc_pin);
      chk("R7 rdata", st_rdata, exp_mode == 0 ? 8'hFF : st_data);
      chk("R7 strobe", st_rd_o, exp_mode == 0 ? 0 : st_rd);
      exp_me = 0; exp_ds = 0;
      for (int k = 0; k < 4; k++) begin
        exp_me += pol(mot[k]) << k;
        exp_ds += pol(sel == k && mot[k]) << k;
      end
      chk("R8 me", me, exp_me);
      chk("R9 ds", ds, exp_ds);
      chk("R10 hdsel", hdsel, pol(hd));
      chk("R10 step", step_o, pol(step));
      chk("R10 dir", dir_o, pol(dir));
      chk("R10 we", we_o, pol(we));
      chk("R10 wdata", wd_o, pol(wd));
      chk("R11 densel", densel, ident ? hi_rate : !hi_rate);
    end
  end

  task automatic scramble(bit straps);
    {mfm_sel, tc_pin, st_rd, hd, step, dir, we, wd, hi_rate} = 9'($urandom);
    st_data = 8'($urandom);
    sel = 2'($urandom);
    mot = 4'($urandom);
    if (straps) begin
      ident = 1'($urandom);
      mfm_pin = 1'($urandom);
      invert = 1'($urandom);
    end
  endtask

  initial begin
    for (int s = 0; s < 4; s++) begin
      @(posedge clk); #1;
      rst = 1;
      ident = s[1]; mfm_pin = s[0];
      repeat (3) begin
        scramble(0);
        @(posedge clk); #1;
      end
      rst = 0;
      // R3: straps move freely after reset; personality must stay
      for (int c = 0; c < 60; c++) begin
        scramble(c > 2);
        @(posedge clk); #1;
      end
      // R9 sweep: every select against every motor pattern, both polarities
      for (int p = 0; p < 2; p++)
        for (int m = 0; m < 16; m++)
          for (int d = 0; d < 4; d++) begin
            invert = p[0]; mot = 4'(m); sel = 2'(d);
            @(posedge clk); #1;
          end
    end
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    fails++;
    $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule